// File: doc/BRIEF.md
# Timer Output Compare Unit

This block contains a free-running up-counter and four output-compare channels, numbered 2 to 5. Each channel has its own compare register and drives one pin. On the cycle in which the counter equals a channel's compare value, the channel sets its event flag. It then acts on its pin according to a two-bit action code: leave the pin alone, invert it, force it low, or force it high.

An 8-bit flag register collects the output-compare events and three input-capture events. The input-capture events arrive as single-cycle strobes from outside. An 8-bit enable mask lines up with the flag register bit for bit. The registered interrupt request is high while any enabled flag is set. One flag position is shared between output compare 5 and input capture 4, and a select input decides which of the two owns it.

Software reaches the unit through a simple register port. Writes are synchronous and reads are combinational. A flag is cleared by writing 1 to its position.

Top module: `oc_timer_unit`

## Requirements
- R1: After reset the counter, the action register, the mask, the flags, every pin and the interrupt output are 0, and every compare register reads 16'hFFFF.
- R2: The counter advances by exactly 1 on every clock and wraps. A write to the counter address does not change its count.
- R3: When the counter equals a channel's compare value, that channel's flag is 1 from the next clock edge. This happens even when the channel's action code is 00.
- R4: Action codes are {mode,level}: 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The pin change is visible one clock after the matching counter value. The action register holds channel 2 in bits [7:6], channel 3 in [5:4], channel 4 in [3:2] and channel 5 in [1:0].
- R5: Flag and mask bit positions are: bit 6 compare 2, bit 5 compare 3, bit 4 compare 4, bit 3 the shared compare 5 / capture 4 source, bit 2 capture 1, bit 1 capture 2, bit 0 capture 3. Bit 7 (compare 1) is never set.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R7: The interrupt output is the OR over all positions of (flag AND mask). It is registered, so it follows the flags one clock later. A flag whose mask bit is 0 never raises it.
- R8: With the select input at 0, bit 3 is set by a compare-5 match and the capture-4 strobe is ignored. With the select input at 1, the capture-4 strobe sets bit 3, and a compare-5 match neither sets the flag nor changes pin 5.
- R9: The register addresses are: 0 action codes, 1 mask, 2 flags, 3 counter (read only), and 4 to 7 the compare registers of channels 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data; 8-bit registers take bits [7:0] |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| ic_sel | input | 1 | 1: shared position is capture 4; 0: compare 5 |
| ic_strobe | input | 4 | Capture strobes, bit 0 = capture 1 … bit 3 = capture 4 |
| pin_out | output | 4 | Channel pins, bit 0 = channel 2 … bit 3 = channel 5 |
| irq | output | 1 | Registered interrupt request |

## Verification
A match is seen in the counter value on the cycle before the edge that acts on it. Flags and pins therefore change one clock after the bench reads a counter value equal to the compare. The interrupt output changes one clock after that, and a strobe or write is reflected in the flags one clock after it is driven. The bench polls the counter on falling edges until it reads the programmed compare value. It then samples pins and flags at the next falling edge and the interrupt output at the one after, so every check lands in the first cycle its result is due.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADR_ACT  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_MASK = 3'd1;
  localparam logic [REG_AW-1:0] ADR_FLAG = 3'd2;
  localparam logic [REG_AW-1:0] ADR_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_CMP0 = 3'd4;

  localparam int FLAG_W = 8;
  localparam int NUM_OC = 4;
endpackage

// File: rtl/oc_free_counter.sv
module oc_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d, cnt_q;

  always_comb cnt_d = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/oc_out_channel.sv
module oc_out_channel
  import oc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic [1:0]   code,
  input  logic         act_en,
  output logic [W-1:0] cmp,
  output logic         match,
  output logic         pin
);
  logic [W-1:0] cmp_d, cmp_q;
  logic         pin_d, pin_q;

  assign match = (cnt == cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_we) cmp_d = wdata;
  end

  always_comb begin
    pin_d = pin_q;
    if (match && act_en) begin
      unique case (pin_act_e'(code))
        ACT_HOLD:   pin_d = pin_q;
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_LOW:    pin_d = 1'b0;
        ACT_HIGH:   pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      pin_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pin_q <= pin_d;
    end
  end

  assign cmp = cmp_q;
  assign pin = pin_q;
endmodule

// File: rtl/oc_flag_bank.sv
module oc_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         flag_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] mask_d, mask_q, flag_d, flag_q, clr_vec;
  logic         irq_d, irq_q;

  always_comb begin
    mask_d  = mask_we ? wdata : mask_q;
    clr_vec = flag_we ? wdata : '0;
    flag_d  = (flag_q & ~clr_vec) | set_vec;
    irq_d   = |(flag_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign mask  = mask_q;
  assign flags = flag_q;
  assign irq   = irq_q;
endmodule

// File: rtl/oc_timer_unit.sv
module oc_timer_unit
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  input  logic                ic_sel,
  input  logic [NUM_OC-1:0]   ic_strobe,
  output logic [NUM_OC-1:0]   pin_out,
  output logic                irq
);
  localparam int CODE_W = 2 * NUM_OC;

  logic [CNT_W-1:0]        cnt_q;
  logic [CODE_W-1:0]       act_d, act_q;
  logic [NUM_OC*CNT_W-1:0] cmp_vals;
  logic [NUM_OC-1:0]       oc_match;
  logic [FLAG_W-1:0]       set_vec, mask_q, flags_q;

  oc_free_counter #(.W(CNT_W)) cnt_i (.clk(clk), .rst_n(rst_n), .cnt(cnt_q));

  always_comb begin
    act_d = act_q;
    if (wr_en && wr_addr == ADR_ACT) act_d = wr_data[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  for (genvar k = 0; k < NUM_OC; k++) begin : g_ch
    localparam logic [REG_AW-1:0] MY_ADR = ADR_CMP0 + REG_AW'(k);
    localparam int HI = CODE_W - 1 - 2 * k;
    logic en_k;
    if (k == NUM_OC - 1) begin : g_shared
      assign en_k = ~ic_sel;
    end else begin : g_plain
      assign en_k = 1'b1;
    end
    oc_out_channel #(.W(CNT_W)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .cmp_we(wr_en && wr_addr == MY_ADR),
      .wdata(wr_data), .cnt(cnt_q),
      .code(act_q[HI -: 2]), .act_en(en_k),
      .cmp(cmp_vals[k*CNT_W +: CNT_W]),
      .match(oc_match[k]), .pin(pin_out[k])
    );
  end

  always_comb begin
    set_vec    = '0;
    set_vec[6] = oc_match[0];
    set_vec[5] = oc_match[1];
    set_vec[4] = oc_match[2];
    set_vec[3] = ic_sel ? ic_strobe[3] : oc_match[3];
    set_vec[2] = ic_strobe[0];
    set_vec[1] = ic_strobe[1];
    set_vec[0] = ic_strobe[2];
  end

  oc_flag_bank #(.N(FLAG_W)) flg_i (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_en && wr_addr == ADR_MASK),
    .flag_we(wr_en && wr_addr == ADR_FLAG),
    .wdata(wr_data[FLAG_W-1:0]), .set_vec(set_vec),
    .mask(mask_q), .flags(flags_q), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_ACT:  rd_data = CNT_W'(act_q);
      ADR_MASK: rd_data = CNT_W'(mask_q);
      ADR_FLAG: rd_data = CNT_W'(flags_q);
      ADR_CNT:  rd_data = cnt_q;
      default:  rd_data = cmp_vals[(32'(rd_addr) - 32'(ADR_CMP0)) * CNT_W +: CNT_W];
    endcase
  end
endmodule

// File: rtl/oc_timer_unit_chk.sv
module oc_timer_unit_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ic_sel,
  input logic [N-1:0] ic_strobe,
  input logic [N-1:0] pin_out,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic [7:0]   flags,
  input logic [7:0]   mask,
  input logic [N*W-1:0] cmp_vals
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == $past(cnt) + W'(1));

  a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp_vals[W-1:0]) |=> flags[6]);

  a_r5_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flags[7] == 1'b0);

  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ic_strobe[0] |=> flags[2]);

  a_r7_irq_lags_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == |($past(flags) & $past(mask)));

  a_r8_pin5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ic_sel) |-> pin_out[N-1] == $past(pin_out[N-1]));
endmodule

bind oc_timer_unit oc_timer_unit_chk #(.W(CNT_W), .N(NUM_OC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ic_sel(ic_sel), .ic_strobe(ic_strobe),
  .pin_out(pin_out), .irq(irq), .cnt(cnt_q), .flags(flags_q),
  .mask(mask_q), .cmp_vals(cmp_vals)
);

// File: tb/oc_timer_unit_tb_top.sv
`timescale 1ns/1ps
module oc_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ic_sel = 1'b0;
  logic [3:0]  ic_strobe = '0;
  logic [3:0]  pin_out;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  oc_timer_unit dut_i (.*);

  // vector fields: {chan[1:0], code[1:0], sel, expected pin, expected flag}
  localparam logic [6:0] VEC [10] = '{
    7'b00_11_0_1_1, 7'b00_01_0_0_1, 7'b00_01_0_1_1, 7'b01_10_0_0_1,
    7'b01_11_0_1_1, 7'b10_00_0_0_1, 7'b10_01_0_1_1, 7'b11_11_0_1_1,
    7'b11_01_1_1_0, 7'b11_10_0_0_1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, c0, tgt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); check("R1 act", v, 16'h0);
    rd(3'd1, v); check("R1 mask", v, 16'h0);
    rd(3'd2, v); check("R1 flags", v, 16'h0);
    rd(3'd4, v); check("R1 cmp", v, 16'hFFFF);
    rd(3'd7, v); check("R1 cmp5", v, 16'hFFFF);
    check("R1 pins", {12'h0, pin_out}, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);

    // R2 counter step, write to counter ignored (R9 read only)
    rd(3'd3, c0);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd3, v); check("R2 step", v, c0 + 16'd1);
    @(negedge clk);
    rd(3'd3, v); check("R2 step2", v, c0 + 16'd2);

    // vector table: R3 R4 R8
    foreach (VEC[i]) begin
      logic [1:0] ch, code;
      logic s, ep, ef;
      {ch, code, s, ep, ef} = VEC[i];
      @(negedge clk); ic_sel = s;
      wr(3'd0, 16'(code) << (6 - 2 * int'(ch)));
      wr(3'd2, 16'h00FF);
      rd(3'd3, c0);
      tgt = c0 + 16'd10;
      wr(3'd4 + 3'(ch), tgt);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        rd(3'd3, v);
        if (v == tgt) break;
      end
      @(negedge clk);
      check("R4 pin action", {15'h0, pin_out[ch]}, {15'h0, ep});
      rd(3'd2, v);
      check("R3 flag on match", {15'h0, v[6 - int'(ch)]}, {15'h0, ef});
    end
    @(negedge clk); ic_sel = 1'b0;
    wr(3'd0, 16'h0000);

    // R5 bit 7 cannot be set, mask readback
    wr(3'd2, 16'h00FF);
    rd(3'd2, v); check("R5 bit7", {15'h0, v[7]}, 16'h0);
    wr(3'd1, 16'h0004);
    rd(3'd1, v); check("R9 mask map", v, 16'h0004);

    // R7 irq timing
    @(negedge clk); ic_strobe = 4'b0001;
    @(negedge clk); ic_strobe = 4'b0000;
    rd(3'd2, v); check("R5 cap1 bit2", v, 16'h0004);
    check("R7 irq not yet", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R7 irq raised", {15'h0, irq}, 16'h1);
    wr(3'd2, 16'h0004);
    rd(3'd2, v); check("R6 w1c", v, 16'h0);
    check("R7 irq lag", {15'h0, irq}, 16'h1);
    @(negedge clk);
    check("R7 irq dropped", {15'h0, irq}, 16'h0);

    // R6 write 0 leaves, set wins
    @(negedge clk); ic_strobe = 4'b0010;
    @(negedge clk); ic_strobe = 4'b0000;
    wr(3'd2, 16'h0000);
    rd(3'd2, v); check("R6 write0", v, 16'h0002);
    @(negedge clk);
    ic_strobe = 4'b0100; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0001;
    @(negedge clk); ic_strobe = 4'b0000; wr_en = 1'b0;
    rd(3'd2, v); check("R6 set wins", v, 16'h0003);
    @(negedge clk); @(negedge clk);
    check("R7 masked", {15'h0, irq}, 16'h0);

    // R8 capture 4 strobe gating
    wr(3'd2, 16'h00FF);
    @(negedge clk); ic_sel = 1'b0; ic_strobe = 4'b1000;
    @(negedge clk); ic_strobe = 4'b0000;
    rd(3'd2, v); check("R8 cap4 ignored", v, 16'h0);
    @(negedge clk); ic_sel = 1'b1; ic_strobe = 4'b1000;
    @(negedge clk); ic_strobe = 4'b0000;
    rd(3'd2, v); check("R8 cap4 sets", v, 16'h0008);

    finish_run();
  end
endmodule